// File: doc/BRIEF.md
# Per-Channel QoS Tag Mapper

This block gives each outgoing command its quality-of-service attributes before it reaches the interconnect fabric. Every master channel has its own attribute register. That register holds a starting order identifier and an arbitration priority. The starting identifier then passes through a shared 16-entry translation table, and the result is the 4-bit order identifier that routing uses. Software can spread traffic across parallel paths by rewriting the table, without touching each channel.

A command arrives as a channel index with a payload. It leaves one clock later with the channel, the payload, the translated order identifier and the priority attached. Configuration uses a word-addressed write port and a combinational read port. Changing an order mapping while commands are still in flight could send return data down the wrong path. For that reason, any write to a mapping register is refused unless the fabric reports that it is idle. A refused write leaves a sticky error flag for software to find and clear.

Top module: `qos_tag_mapper`

## Requirements
- R1: After reset, every channel register reads 0 and the translation table holds the identity mapping. A command from any channel is therefore tagged with order 0 and priority 0, and the error flag reads 0.
- R2: Channel register at word address c (c < NUM_CH) keeps the starting order in bits 7:4 and the priority in bits 14:12. All other bits read as 0.
- R3: Table entry k sits in bits 4k+3:4k of word NUM_CH when k < 8, and in bits 4(k-8)+3:4(k-8) of word NUM_CH+1 when k >= 8. The tagged order equals the table entry indexed by the channel's starting order.
- R4: When cmd_valid is high, the next cycle shows tag_valid high, with the same channel and payload, the translated order and the channel's priority.
- R5: In the cycle after cmd_valid is low, tag_valid is low.
- R6: A write to a channel register or a table word while fabric_idle is low is dropped, and the stored mapping is unchanged.
- R7: A dropped write sets bit 0 of the status word at address NUM_CH+2. That bit stays set until it is cleared.
- R8: Writing the status word with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag as it is. Bit 1 of the status word reads the current fabric_idle.
- R9: cfg_rdata shows, in the same cycle, the stored content of the word that cfg_addr selects, including the effect of every write accepted at an earlier edge.
- R10: Addresses above NUM_CH+2 read as 0, and writes to them change nothing.
- R11: A command whose channel index is NUM_CH or higher is tagged with priority 0 and with the table entry for starting order 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fabric_idle | input | 1 | High when the fabric has no transaction outstanding |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| cmd_valid | input | 1 | Incoming command valid |
| cmd_ch | input | CH_W | Master channel index of the command |
| cmd_payload | input | PAYLOAD_W | Command content passed through |
| tag_valid | output | 1 | Tagged command valid |
| tag_ch | output | CH_W | Channel index of the tagged command |
| tag_payload | output | PAYLOAD_W | Payload of the tagged command |
| tag_order | output | 4 | Translated order identifier |
| tag_prio | output | 3 | Arbitration priority |

## Verification
The assertions assume that cmd_valid and cfg_we are low while reset is held. They also assume that one configuration write happens per cycle, so a flag-clearing write can never coincide with a refused mapping write. The stimulus drives every input one nanosecond after the rising edge and keeps all strobes low during reset. In the random phase, fabric_idle, the channel index (including out-of-range values) and the write address (including unmapped words) change freely. This covers refused writes, flag clears and commands that coincide with writes.

// File: rtl/qos_tag_pkg.sv
`timescale 1ns/1ps
package qos_tag_pkg;
   localparam int ORD_W        = 4;
   localparam int PRIO_W       = 3;
   localparam int CFG_DW       = 32;
   localparam int ORD_LSB      = 4;
   localparam int PRIO_LSB     = 12;
   localparam int REMAP_N      = 1 << ORD_W;
   localparam int NIB_PER_WORD = CFG_DW / ORD_W;
   localparam int REMAP_WORDS  = REMAP_N / NIB_PER_WORD;

   typedef struct packed {
      logic [ORD_W-1:0]  ord;
      logic [PRIO_W-1:0] prio;
   } qos_attr_t;

   function automatic int idx_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/qos_chan_regs.sv
`timescale 1ns/1ps
module qos_chan_regs
   import qos_tag_pkg::*;
#(
   parameter int NUM_CH = 6,
   parameter int CH_W   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_req,
   input  logic            wr_ok,
   input  logic [CH_W-1:0] wr_idx,
   input  qos_attr_t       wr_attr,
   input  logic [CH_W-1:0] rd_idx,
   output qos_attr_t       rd_attr,
   input  logic [CH_W-1:0] tag_idx,
   output qos_attr_t       tag_attr
);
   qos_attr_t [NUM_CH-1:0] attr_q;
   logic                   wr_fire;

   assign wr_fire = wr_req && wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr_q <= '0;
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (wr_fire && wr_idx == CH_W'(c)) attr_q[c] <= wr_attr;
         end
      end
   end

   always_comb begin
      rd_attr  = '0;
      tag_attr = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_idx == CH_W'(c))  rd_attr  = attr_q[c];
         if (tag_idx == CH_W'(c)) tag_attr = attr_q[c];
      end
   end

   AST_CH_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ok) |=> $stable(attr_q)); // R6
endmodule

// File: rtl/qos_remap_table.sv
`timescale 1ns/1ps
module qos_remap_table
   import qos_tag_pkg::*;
#(
   parameter int WSEL_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              wr_ok,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [CFG_DW-1:0] wr_data,
   input  logic [WSEL_W-1:0] rd_word,
   output logic [CFG_DW-1:0] rd_data,
   input  logic [ORD_W-1:0]  lk_in,
   output logic [ORD_W-1:0]  lk_out
);
   logic [REMAP_N-1:0][ORD_W-1:0]   map_q;
   logic [REMAP_WORDS-1:0][CFG_DW-1:0] word_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < REMAP_N; k++) map_q[k] <= ORD_W'(k);
      end else if (wr_req && wr_ok) begin
         for (int k = 0; k < REMAP_N; k++) begin
            if (wr_word == WSEL_W'(k / NIB_PER_WORD))
               map_q[k] <= wr_data[(k % NIB_PER_WORD)*ORD_W +: ORD_W];
         end
      end
   end

   for (genvar w = 0; w < REMAP_WORDS; w++) begin : g_word
      assign word_view[w] = map_q[w*NIB_PER_WORD +: NIB_PER_WORD];
   end

   assign rd_data = word_view[rd_word];
   assign lk_out  = map_q[lk_in];

   AST_REMAP_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ok) |=> $stable(map_q)); // R6
endmodule

// File: rtl/qos_tag_mapper.sv
`timescale 1ns/1ps
module qos_tag_mapper
   import qos_tag_pkg::*;
#(
   parameter int NUM_CH    = 6,
   parameter int PAYLOAD_W = 16,
   parameter int CFG_AW    = 4,
   parameter int CH_W      = idx_w(NUM_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fabric_idle,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [CFG_DW-1:0]    cfg_wdata,
   output logic [CFG_DW-1:0]    cfg_rdata,
   input  logic                 cmd_valid,
   input  logic [CH_W-1:0]      cmd_ch,
   input  logic [PAYLOAD_W-1:0] cmd_payload,
   output logic                 tag_valid,
   output logic [CH_W-1:0]      tag_ch,
   output logic [PAYLOAD_W-1:0] tag_payload,
   output logic [ORD_W-1:0]     tag_order,
   output logic [PRIO_W-1:0]    tag_prio
);
   localparam int RM_BASE = NUM_CH;
   localparam int ST_ADDR = NUM_CH + REMAP_WORDS;
   localparam int WSEL_W  = idx_w(REMAP_WORDS);

   initial begin
      AST_CFG_SPAN: assert ((1 << CFG_AW) > ST_ADDR && CH_W <= CFG_AW && NUM_CH >= 1)
         else $error("address space too small for NUM_CH");
      AST_CH_W_FITS: assert ((1 << CH_W) >= NUM_CH)
         else $error("CH_W cannot index all channels");
   end

   logic              sel_ch, sel_rm, sel_st;
   logic              map_wr, st_clr;
   logic [WSEL_W-1:0] rm_sel;
   qos_attr_t         wr_attr, rd_attr, ch_attr;
   logic [CFG_DW-1:0] rm_rdata;
   logic [ORD_W-1:0]  final_ord;
   logic              err_q;

   assign sel_ch = cfg_addr < CFG_AW'(RM_BASE);
   assign sel_rm = (cfg_addr >= CFG_AW'(RM_BASE)) && (cfg_addr < CFG_AW'(ST_ADDR));
   assign sel_st = cfg_addr == CFG_AW'(ST_ADDR);
   assign rm_sel = WSEL_W'(cfg_addr - CFG_AW'(RM_BASE));
   assign map_wr = cfg_we && (sel_ch || sel_rm);
   assign st_clr = cfg_we && sel_st && cfg_wdata[0];

   assign wr_attr.ord  = cfg_wdata[ORD_LSB +: ORD_W];
   assign wr_attr.prio = cfg_wdata[PRIO_LSB +: PRIO_W];

   qos_chan_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (cfg_we && sel_ch),
      .wr_ok    (fabric_idle),
      .wr_idx   (cfg_addr[CH_W-1:0]),
      .wr_attr  (wr_attr),
      .rd_idx   (cfg_addr[CH_W-1:0]),
      .rd_attr  (rd_attr),
      .tag_idx  (cmd_ch),
      .tag_attr (ch_attr)
   );

   qos_remap_table #(.WSEL_W(WSEL_W)) u_remap (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (cfg_we && sel_rm),
      .wr_ok   (fabric_idle),
      .wr_word (rm_sel),
      .wr_data (cfg_wdata),
      .rd_word (rm_sel),
      .rd_data (rm_rdata),
      .lk_in   (ch_attr.ord),
      .lk_out  (final_ord)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      err_q <= 1'b0;
      else if (map_wr && !fabric_idle) err_q <= 1'b1;
      else if (st_clr)                 err_q <= 1'b0;
   end

   always_comb begin
      cfg_rdata = '0;
      if (sel_ch) begin
         cfg_rdata[ORD_LSB +: ORD_W]   = rd_attr.ord;
         cfg_rdata[PRIO_LSB +: PRIO_W] = rd_attr.prio;
      end else if (sel_rm) begin
         cfg_rdata = rm_rdata;
      end else if (sel_st) begin
         cfg_rdata[0] = err_q;
         cfg_rdata[1] = fabric_idle;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_valid   <= 1'b0;
         tag_ch      <= '0;
         tag_payload <= '0;
         tag_order   <= '0;
         tag_prio    <= '0;
      end else begin
         tag_valid <= cmd_valid;
         if (cmd_valid) begin
            tag_ch      <= cmd_ch;
            tag_payload <= cmd_payload;
            tag_order   <= final_ord;
            tag_prio    <= ch_attr.prio;
         end
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> tag_valid); // R4
   AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> (tag_payload == $past(cmd_payload) && tag_ch == $past(cmd_ch))); // R4
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !tag_valid); // R5
   AST_ERR_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr && !fabric_idle) |=> err_q); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !st_clr) |=> err_q); // R7
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      st_clr |=> !err_q); // R8
   AST_OOR_CH_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && int'(cmd_ch) >= NUM_CH) |=> tag_prio == '0); // R11
endmodule

// File: tb/qos_tag_mapper_tb.sv
`timescale 1ns/1ps
module qos_tag_mapper_tb;
   localparam int NCH = 6;
   localparam int PW  = 16;
   localparam int AW  = 4;
   localparam int CW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fabric_idle = 1'b1;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          cmd_valid = 1'b0;
   logic [CW-1:0] cmd_ch = '0;
   logic [PW-1:0] cmd_payload = '0;
   logic          tag_valid;
   logic [CW-1:0] tag_ch;
   logic [PW-1:0] tag_payload;
   logic [3:0]    tag_order;
   logic [2:0]    tag_prio;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   qos_tag_mapper #(.NUM_CH(NCH), .PAYLOAD_W(PW), .CFG_AW(AW), .CH_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .fabric_idle(fabric_idle),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cmd_valid(cmd_valid), .cmd_ch(cmd_ch), .cmd_payload(cmd_payload),
      .tag_valid(tag_valid), .tag_ch(tag_ch), .tag_payload(tag_payload),
      .tag_order(tag_order), .tag_prio(tag_prio)
   );

   // behavioural reference state
   int m_ord[NCH];
   int m_prio[NCH];
   int m_rm[16];
   bit m_err;
   bit e_valid;
   int e_ord, e_prio, e_ch, e_pay;
   int c_i, io_i, a_i;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic m_reset();
      for (int k = 0; k < NCH; k++) begin m_ord[k] = 0; m_prio[k] = 0; end
      for (int k = 0; k < 16; k++) m_rm[k] = k;
      m_err = 0;
      e_valid = 0;
   endtask

   function automatic logic [31:0] m_read(input int a, input bit idle);
      logic [31:0] v;
      v = '0;
      if (a < NCH) begin
         v[7:4] = 4'(m_ord[a]);
         v[14:12] = 3'(m_prio[a]);
      end else if (a == NCH) begin
         for (int k = 0; k < 8; k++) v[4*k +: 4] = 4'(m_rm[k]);
      end else if (a == NCH + 1) begin
         for (int k = 0; k < 8; k++) v[4*k +: 4] = 4'(m_rm[8+k]);
      end else if (a == NCH + 2) begin
         v[0] = m_err;
         v[1] = idle;
      end
      return v;
   endfunction

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reset();
      end else begin
         e_valid = cmd_valid;
         if (cmd_valid) begin
            c_i = int'(cmd_ch);
            io_i = (c_i < NCH) ? m_ord[c_i] : 0;
            e_ord = m_rm[io_i];
            e_prio = (c_i < NCH) ? m_prio[c_i] : 0;
            e_ch = c_i;
            e_pay = int'(cmd_payload);
         end
         if (cfg_we) begin
            a_i = int'(cfg_addr);
            if ((a_i < NCH + 2) && !fabric_idle) begin
               m_err = 1;
            end else if (a_i < NCH) begin
               m_ord[a_i] = int'(cfg_wdata[7:4]);
               m_prio[a_i] = int'(cfg_wdata[14:12]);
            end else if (a_i == NCH) begin
               for (int k = 0; k < 8; k++) m_rm[k] = int'(cfg_wdata[4*k +: 4]);
            end else if (a_i == NCH + 1) begin
               for (int k = 0; k < 8; k++) m_rm[8+k] = int'(cfg_wdata[4*k +: 4]);
            end else if (a_i == NCH + 2 && cfg_wdata[0]) begin
               m_err = 0;
            end
         end
      end
   end

   // per-cycle comparison against the reference model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 valid", 32'(tag_valid), 32'(e_valid));
         if (e_valid) begin
            chk("R4 order", 32'(tag_order), 32'(e_ord));
            chk("R4 prio", 32'(tag_prio), 32'(e_prio));
            chk("R4 ch", 32'(tag_ch), 32'(e_ch));
            chk("R4 payload", 32'(tag_payload), 32'(e_pay));
         end
         chk("R9 readback", cfg_rdata, m_read(int'(cfg_addr), fabric_idle));
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
      @(posedge clk); #1;
      cfg_addr = AW'(a);
      #1;
      chk(req, cfg_rdata, exp);
   endtask

   task automatic send(input int ch, input int pay);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_ch = CW'(ch); cmd_payload = PW'(pay);
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1 chan reg", 0, 32'h0);
      rd_chk("R1 remap lo", NCH, 32'h7654_3210);
      rd_chk("R1 remap hi", NCH + 1, 32'hFEDC_BA98);
      rd_chk("R1 status", NCH + 2, 32'h2);
      send(3, 16'h1234);
      chk("R1 order", 32'(tag_order), 32'h0);
      chk("R1 prio", 32'(tag_prio), 32'h0);

      // R2 field positions
      wr(2, 32'hFFFF_FFFF);
      rd_chk("R2 masked fields", 2, 32'h0000_70F0);

      // R3 two-stage mapping
      wr(1, 32'h0000_5090);
      wr(NCH + 1, 32'hFEDC_BAC8);
      rd_chk("R3 remap word", NCH + 1, 32'hFEDC_BAC8);
      send(1, 16'hBEEF);
      chk("R3 order", 32'(tag_order), 32'hC);
      chk("R3 prio", 32'(tag_prio), 32'h5);

      // R6 and R7 busy writes
      @(posedge clk); #1 fabric_idle = 1'b0;
      wr(1, 32'h0);
      rd_chk("R6 chan kept", 1, 32'h0000_5090);
      wr(NCH + 1, 32'h0);
      send(1, 16'h0F0F);
      chk("R6 remap kept", 32'(tag_order), 32'hC);
      rd_chk("R7 err set", NCH + 2, 32'h1);
      repeat (3) @(posedge clk);
      rd_chk("R7 err sticky", NCH + 2, 32'h1);

      // R8 clear
      @(posedge clk); #1 fabric_idle = 1'b1;
      wr(NCH + 2, 32'h0);
      rd_chk("R8 zero no clear", NCH + 2, 32'h3);
      wr(NCH + 2, 32'h1);
      rd_chk("R8 cleared", NCH + 2, 32'h2);

      // R10 unmapped
      wr(10, 32'hFFFF_FFFF);
      rd_chk("R10 reads zero", 10, 32'h0);
      rd_chk("R10 no side effect", 2, 32'h0000_70F0);
      rd_chk("R10 status clean", NCH + 2, 32'h2);

      // R11 out-of-range channel
      wr(NCH, 32'h7654_3213);
      send(7, 16'h00AA);
      chk("R11 order", 32'(tag_order), 32'h3);
      chk("R11 prio", 32'(tag_prio), 32'h0);
      send(6, 16'h00BB);
      chk("R11 order ch6", 32'(tag_order), 32'h3);

      // R5 idle cycle
      @(negedge clk);
      chk("R5 no command", 32'(tag_valid), 32'h0);

      // random traffic against the reference model
      for (int i = 0; i < 600; i++) begin
         @(posedge clk); #1;
         cmd_valid = 1'($urandom % 2);
         cmd_ch = CW'($urandom % 8);
         cmd_payload = PW'($urandom);
         fabric_idle = ($urandom % 4) != 0;
         cfg_we = ($urandom % 3) == 0;
         cfg_addr = AW'($urandom % 12);
         cfg_wdata = $urandom;
      end
      @(posedge clk); #1;
      cmd_valid = 1'b0; cfg_we = 1'b0;
      repeat (2) @(negedge clk);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule